// File: doc/BRIEF.md
# Multivalued Parameter Address Resolver

A simulation engine stores every value a multivalued parameter can take as one contiguous array, with one element per operating case. Such parameters come from switches modelled as two-valued resistances and from piecewise-linear elements. The resolver turns a descriptor word into the memory address of the value that currently applies.

Each descriptor carries the array start address, the address of a state word, a decode rule and a flag that says which state store to read. One store holds state written by arithmetic results. The other holds state set by external device inputs. The resolver reads the state word from the chosen store and decodes it into an offset. It clamps the offset to the last array element when needed and adds it to the start address. The block is fully pipelined: it accepts one descriptor every cycle and returns each result a fixed two cycles later.

Top module: `mv_addr_resolver`

## Requirements
- R1: The descriptor word `boot_word_i` is 25 bits wide, with fields laid out from the most significant bit:
  - bit 24 selects the state source (0 = internal, 1 = external);
  - bits 23:22 hold the decode mode;
  - bits 21:12 hold the state-word address;
  - bits 11:0 hold the array start address.
- R2: In the cycle `boot_valid_i` is high, exactly one read enable is high: `int_rd_en_o` if the source bit is 0, `ext_rd_en_o` if it is 1. The chosen port's address equals the state-word address field. Both enables are low when `boot_valid_i` is low. Each store returns data one clock after the read.
- R3: Mode 0 (direct) uses state bits 3:0 as the offset. The highest offset allowed is 11.
- R4: Mode 1 (switch) uses state bit 0 as the offset, 0 or 1.
- R5: Mode 2 (priority) uses the index of the highest set bit of the 16-bit state word as the offset, and 0 when the word is zero. The highest offset allowed is 7.
- R6: Mode 3 (four cases) uses state bits 1:0 as the offset.
- R7: `addr_o` equals the start address plus the offset, modulo 4096. `addr_valid_o` is high exactly two clock edges after the edge that sampled `boot_valid_i`, and one descriptor can be accepted every cycle.
- R8: An offset above its mode's limit is replaced by the limit. `clamp_err_o` rises with that result and stays high until reset.
- R9: While `rst_ni` is low, `addr_valid_o`, `addr_o` and `clamp_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_valid_i | input | 1 | Descriptor present |
| boot_word_i | input | 25 | Descriptor word |
| int_rd_en_o | output | 1 | Internal state store read enable |
| int_rd_addr_o | output | 10 | Internal state store read address |
| int_rd_data_i | input | 16 | Internal state word, one cycle after the read |
| ext_rd_en_o | output | 1 | External state store read enable |
| ext_rd_addr_o | output | 10 | External state store read address |
| ext_rd_data_i | input | 16 | External state word, one cycle after the read |
| addr_valid_o | output | 1 | Resolved address valid |
| addr_o | output | 12 | Resolved parameter address |
| clamp_err_o | output | 1 | Sticky clamp error flag |

## Verification
The read enable and read address are due in the same cycle as the descriptor, so the bench checks them just before the next rising edge. The resolved address and the error flag are due two edges after the descriptor is sampled. The bench drives one descriptor at every falling edge and keeps a two-deep queue of expected results. At each falling edge it compares the outputs against the entry queued two cycles earlier, and then drives the next descriptor. Because the state stores are left unchanged during a stream, each expected value depends only on the descriptor and on what the stores hold.

// File: rtl/mv_resolver_pkg.sv
package mv_resolver_pkg;
  localparam int START_W = 12;
  localparam int AADDR_W = 10;
  localparam int STATE_W = 16;
  localparam int MODE_W  = 2;
  localparam int BOOT_W  = 1 + MODE_W + AADDR_W + START_W;
  localparam int OFF_W   = $clog2(STATE_W);

  typedef enum logic [MODE_W-1:0] {
    MODE_DIRECT = 2'd0,
    MODE_SWITCH = 2'd1,
    MODE_PRIO   = 2'd2,
    MODE_CASE4  = 2'd3
  } dec_mode_e;

  typedef struct packed {
    logic                 src_ext;
    dec_mode_e            mode;
    logic [AADDR_W-1:0]   aff_addr;
    logic [START_W-1:0]   start;
  } boot_word_t;
endpackage

// File: rtl/mv_boot_stage.sv
module mv_boot_stage
  import mv_resolver_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  boot_word_t         boot_i,
  output logic               valid_o,
  output logic               src_ext_o,
  output dec_mode_e          mode_o,
  output logic [START_W-1:0] start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      src_ext_o <= 1'b0;
      mode_o    <= MODE_DIRECT;
      start_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        src_ext_o <= boot_i.src_ext;
        mode_o    <= boot_i.mode;
        start_o   <= boot_i.start;
      end
    end
  end
endmodule

// File: rtl/mv_offset_decoder.sv
module mv_offset_decoder
  import mv_resolver_pkg::*;
#(
  parameter int DIRECT_LIM = 11,
  parameter int PRIO_LIM   = 7
) (
  input  dec_mode_e          mode_i,
  input  logic [STATE_W-1:0] state_i,
  output logic [OFF_W-1:0]   off_o,
  output logic [OFF_W-1:0]   lim_o,
  output logic               clamp_o
);
  logic [OFF_W-1:0] raw_off;
  logic [OFF_W-1:0] prio_idx;

  // highest set bit wins; later iterations override earlier
  always_comb begin
    prio_idx = '0;
    for (int b = 0; b < STATE_W; b++) begin
      if (state_i[b]) prio_idx = OFF_W'(b);
    end
  end

  always_comb begin
    unique case (mode_i)
      MODE_DIRECT: begin raw_off = state_i[OFF_W-1:0];           lim_o = OFF_W'(DIRECT_LIM); end
      MODE_SWITCH: begin raw_off = OFF_W'(state_i[0]);           lim_o = OFF_W'(1);          end
      MODE_PRIO:   begin raw_off = prio_idx;                     lim_o = OFF_W'(PRIO_LIM);   end
      default:     begin raw_off = OFF_W'(state_i[1:0]);         lim_o = OFF_W'(3);          end
    endcase
  end

  assign clamp_o = raw_off > lim_o;
  assign off_o   = clamp_o ? lim_o : raw_off;
endmodule

// File: rtl/mv_addr_resolver.sv
module mv_addr_resolver
  import mv_resolver_pkg::*;
#(
  parameter int DIRECT_LIM = 11,
  parameter int PRIO_LIM   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               boot_valid_i,
  input  logic [BOOT_W-1:0]  boot_word_i,
  output logic               int_rd_en_o,
  output logic [AADDR_W-1:0] int_rd_addr_o,
  input  logic [STATE_W-1:0] int_rd_data_i,
  output logic               ext_rd_en_o,
  output logic [AADDR_W-1:0] ext_rd_addr_o,
  input  logic [STATE_W-1:0] ext_rd_data_i,
  output logic               addr_valid_o,
  output logic [START_W-1:0] addr_o,
  output logic               clamp_err_o
);
  boot_word_t         boot;
  logic               s1_valid;
  logic               s1_src_ext;
  dec_mode_e          s1_mode;
  logic [START_W-1:0] s1_start;
  logic [STATE_W-1:0] state_word;
  logic [OFF_W-1:0]   off;
  logic [OFF_W-1:0]   lim;
  logic               clamp;

  assign boot          = boot_word_t'(boot_word_i);
  assign int_rd_en_o   = boot_valid_i & ~boot.src_ext;
  assign ext_rd_en_o   = boot_valid_i &  boot.src_ext;
  assign int_rd_addr_o = boot.aff_addr;
  assign ext_rd_addr_o = boot.aff_addr;

  mv_boot_stage u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (boot_valid_i),
    .boot_i   (boot),
    .valid_o  (s1_valid),
    .src_ext_o(s1_src_ext),
    .mode_o   (s1_mode),
    .start_o  (s1_start)
  );

  assign state_word = s1_src_ext ? ext_rd_data_i : int_rd_data_i;

  mv_offset_decoder #(
    .DIRECT_LIM(DIRECT_LIM),
    .PRIO_LIM  (PRIO_LIM)
  ) u_dec (
    .mode_i (s1_mode),
    .state_i(state_word),
    .off_o  (off),
    .lim_o  (lim),
    .clamp_o(clamp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_valid_o <= 1'b0;
      addr_o       <= '0;
      clamp_err_o  <= 1'b0;
    end else begin
      addr_valid_o <= s1_valid;
      if (s1_valid) begin
        addr_o <= s1_start + START_W'(off);
        if (clamp) clamp_err_o <= 1'b1;
      end
    end
  end

  // R2: one read port per descriptor
  p_one_port_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({int_rd_en_o, ext_rd_en_o}) && (boot_valid_i == (int_rd_en_o | ext_rd_en_o)));

  // R7: fixed two-edge latency
  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_valid_i |=> s1_valid ##1 addr_valid_o);

  // R8: decoded offset never beyond the mode limit
  p_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |-> (off <= lim));

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_err_o |=> clamp_err_o);

  // R7: no result without a descriptor two edges back
  p_no_spurious_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid |=> !addr_valid_o);
endmodule

// File: tb/mv_addr_resolver_bench.sv
module mv_addr_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_valid = 1'b0;
  logic [24:0] boot_word = '0;
  logic        int_en, ext_en;
  logic [9:0]  int_addr, ext_addr;
  logic [15:0] int_q = '0, ext_q = '0;
  logic        addr_valid, clamp_err;
  logic [11:0] addr;

  logic [15:0] int_mem [1024];
  logic [15:0] ext_mem [1024];

  int total = 0, bad = 0;
  bit exp_err = 1'b0;
  // two-deep expectation pipe
  bit          pv [2];
  logic [11:0] pa [2];
  bit          pe [2];

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (int_en) int_q <= int_mem[int_addr];
    if (ext_en) ext_q <= ext_mem[ext_addr];
  end

  mv_addr_resolver u_mv_addr_resolver (
    .clk_i(clk), .rst_ni(rst_n),
    .boot_valid_i(boot_valid), .boot_word_i(boot_word),
    .int_rd_en_o(int_en), .int_rd_addr_o(int_addr), .int_rd_data_i(int_q),
    .ext_rd_en_o(ext_en), .ext_rd_addr_o(ext_addr), .ext_rd_data_i(ext_q),
    .addr_valid_o(addr_valid), .addr_o(addr), .clamp_err_o(clamp_err)
  );

  function automatic logic [24:0] mk(bit src, logic [1:0] mode, logic [9:0] aa, logic [11:0] st);
    return {src, mode, aa, st};
  endfunction

  function automatic int raw_off(logic [1:0] mode, logic [15:0] s);
    int idx = 0;
    case (mode)
      2'd0: return int'(s[3:0]);
      2'd1: return int'(s[0]);
      2'd2: begin
        for (int b = 0; b < 16; b++) if (s[b]) idx = b;
        return idx;
      end
      default: return int'(s[1:0]);
    endcase
  endfunction

  function automatic int lim_of(logic [1:0] mode);
    case (mode)
      2'd0: return 11;
      2'd1: return 1;
      2'd2: return 7;
      default: return 3;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // one cycle: check outputs due now, then drive v/w
  task automatic step(bit v, logic [24:0] w, string req);
    logic [15:0] s;
    int o, lm;
    bit cl;
    check(addr_valid == pv[0], "R7", "addr_valid_o", addr_valid, pv[0]);
    if (pv[0]) check(addr == pa[0], req, "addr_o", addr, pa[0]);
    check(clamp_err == pe[0], "R8", "clamp_err_o", clamp_err, pe[0]);
    boot_valid = v;
    boot_word  = w;
    pv[0] = pv[1]; pa[0] = pa[1]; pe[0] = pe[1];
    pv[1] = v;
    if (v) begin
      s  = w[24] ? ext_mem[w[21:12]] : int_mem[w[21:12]];
      o  = raw_off(w[23:22], s);
      lm = lim_of(w[23:22]);
      cl = o > lm;
      if (cl) o = lm;
      if (cl) exp_err = 1'b1;
      pa[1] = w[11:0] + 12'(o);
    end
    pe[1] = exp_err;
    #1;
    check((int_en == (v & ~w[24])) && (ext_en == (v & w[24])), "R2", "rd_en",
          {int_en, ext_en}, {v & ~w[24], v & w[24]});
    if (v) check((w[24] ? ext_addr : int_addr) == w[21:12], "R2", "rd_addr",
                 w[24] ? ext_addr : int_addr, w[21:12]);
    @(negedge clk);
  endtask

  task automatic flush();
    step(1'b0, '0, "R7");
    step(1'b0, '0, "R7");
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 1024; i++) begin
      int_mem[i] = 16'($urandom);
      ext_mem[i] = 16'($urandom);
    end
    // directed contents
    int_mem[1] = 16'h000b;   // mode0 at limit
    int_mem[2] = 16'h0003;
    ext_mem[3] = 16'h0001;
    ext_mem[4] = 16'h0000;
    int_mem[5] = 16'h0000;   // prio of zero
    int_mem[6] = 16'h0041;   // prio -> 6
    ext_mem[7] = 16'h00ff;   // prio -> 7, at limit
    int_mem[8] = 16'hfff2;   // case4 -> 2
    int_mem[9] = 16'h000c;   // mode0 12 -> clamp
    ext_mem[10] = 16'h8000;  // prio 15 -> clamp 7
    pv = '{0, 0}; pa = '{0, 0}; pe = '{0, 0};

    repeat (3) @(negedge clk);
    check(addr_valid == 1'b0, "R9", "reset valid", addr_valid, 0);
    check(addr == 12'h0, "R9", "reset addr", addr, 0);
    check(clamp_err == 1'b0, "R9", "reset err", clamp_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed, back to back, no clamps
    step(1'b1, mk(0, 2'd0, 10'd1, 12'h100), "R3");
    step(1'b1, mk(0, 2'd1, 10'd2, 12'h200), "R4");
    step(1'b1, mk(1, 2'd1, 10'd4, 12'h200), "R4");
    step(1'b1, mk(0, 2'd2, 10'd5, 12'h300), "R5");
    step(1'b1, mk(0, 2'd2, 10'd6, 12'h300), "R5");
    step(1'b1, mk(1, 2'd2, 10'd7, 12'h300), "R5");
    step(1'b1, mk(0, 2'd3, 10'd8, 12'h400), "R6");
    step(1'b1, mk(1, 2'd1, 10'd3, 12'hfff), "R7");  // wraps to 000
    step(1'b1, mk(0, 2'd3, 10'd2, 12'hffe), "R7");  // wraps to 001
    step(1'b0, '0, "R7");
    step(1'b1, mk(1, 2'd0, 10'd1, 12'h050), "R1");
    flush();
    // clamp cases
    step(1'b1, mk(0, 2'd0, 10'd9, 12'h500), "R8");
    step(1'b1, mk(1, 2'd2, 10'd10, 12'h600), "R8");
    flush();
    flush();  // flag must stay set

    // random stream
    for (int n = 0; n < 400; n++) begin
      bit v = ($urandom % 4) != 0;
      step(v, 25'($urandom), "R7");
    end
    flush();

    // reset clears sticky flag
    rst_n = 1'b0;
    #1;
    check(clamp_err == 1'b0, "R9", "err after reset", clamp_err, 0);
    check(addr_valid == 1'b0, "R9", "valid after reset", addr_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_err = 1'b0;
    pv = '{0, 0}; pe = '{0, 0};
    @(negedge clk);
    step(1'b1, mk(0, 2'd0, 10'd1, 12'h010), "R3");
    flush();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule